// File: doc/BRIEF.md
# Nonvolatile Memory Operation Sequencer

This block is a 16-bit control register that launches and times program and erase operations on a nonvolatile memory array. Software writes the register to choose an operation (a 4-bit selector plus an erase/program mode bit) and to request a start. The block then decodes the pair into a single command, emits a one-cycle start strobe, and holds a busy flag for a fixed number of cycles that depends on the command class. At the end of that window hardware clears the start bit.

Only a power-on reset clears the register. The ordinary system reset is sampled on the clock. While idle it leaves every bit untouched. While an operation runs it cuts that operation short, and the block records the abnormal end in a sticky sequence-error flag. A start request with writes disabled, or with a selector/mode pair that names no operation, also raises that flag and launches nothing.

Top module: `nvm_op_ctrl`

## Requirements
- R1: Read data shows start at bit 15, write-enable at bit 14, sequence error at bit 13, mode at bit 6 and selector at bits 3:0; bits 12:7 and 5:4 always read 0 and writes to them have no effect.
- R2: After power-on reset the read data is 0, busy and the strobe are low and the command output is 0 (none).
- R3: Command codes on op_cmd: mode 1 with selector 1111 gives 1 (bulk erase), 1101 gives 2 (general segment erase), 1100 gives 3 (secure segment erase), 0010 gives 4 (page erase); mode 0 with 0001 gives 5 (row program), 0011 gives 6 (word program); selector 0000 in either mode gives 7 (configuration byte); every other pair gives 0 (none).
- R4: A write with bits 15 and 14 set and a pair that decodes to a nonzero command, made while idle, sets start and busy and drives the command after the write edge, and raises op_start for exactly that one cycle.
- R5: Busy stays high for the cycle count of the launched command (bulk, segment, page, row, word and configuration byte each have their own parameter); on the edge after that, busy and the start bit clear together and op_cmd returns to 0.
- R6: Software cannot clear the start bit: a write with bit 15 at 0 during an operation leaves start and busy unchanged.
- R7: A start request while idle with bit 14 of the write at 0, or with a pair that decodes to none, sets the error flag, leaves start at 0 and raises neither busy nor op_start.
- R8: The error flag is sticky: software writes to bit 13 have no effect and only power-on reset clears it.
- R9: While busy, writes to the mode and selector bits and further start requests are ignored; the write-enable bit stays writable.
- R10: While the system reset is low and no operation runs, all register bits keep their values and register writes are ignored.
- R11: A system reset low during an operation ends it: on that edge busy falls, start clears, op_cmd returns to 0 and the error flag sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, sampled on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| op_start | output | 1 | One-cycle operation start strobe |
| op_cmd | output | 3 | Decoded command of the running operation |
| op_busy | output | 1 | High while a timed operation runs |

## Verification
The hardest cases to reach are the ones where two events land on the same edge or inside a running operation: a system reset pulse part-way through a timed window, and register writes that try to change the selector, clear start or request a second start while busy. The stimulus launches long commands and then times writes and reset pulses a few cycles into the busy window. A behavioural reference model, compared on every cycle, then shows whether the command held, the window ended at the expected edge and the error flag moved as it should.

// File: rtl/nvm_op_pkg.sv
package nvm_op_pkg;

    localparam int REG_W = 16;
    localparam int SEL_W = 4;
    localparam int CMD_W = 3;

    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_ERR   = 13;
    localparam int BIT_MODE  = 6;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE     = 3'd0,
        CMD_BULK     = 3'd1,
        CMD_GEN_SEG  = 3'd2,
        CMD_SEC_SEG  = 3'd3,
        CMD_PAGE     = 3'd4,
        CMD_ROW      = 3'd5,
        CMD_WORD     = 3'd6,
        CMD_CFG_BYTE = 3'd7
    } cmd_e;

endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
    import nvm_op_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int T_BULK     = 12,
    parameter int T_SEG      = 10,
    parameter int T_PAGE     = 8,
    parameter int T_ROW      = 6,
    parameter int T_WORD     = 4,
    parameter int T_CFG      = 3
) (
    input  logic             mode_i,
    input  logic [SEL_W-1:0] sel_i,
    output cmd_e             cmd_o,
    output logic [CNT_W-1:0] dur_m1_o
);

    always_comb begin
        cmd_o = CMD_NONE;
        unique case (sel_i)
            4'b1111: cmd_o = mode_i ? CMD_BULK    : CMD_NONE;
            4'b1101: cmd_o = mode_i ? CMD_GEN_SEG : CMD_NONE;
            4'b1100: cmd_o = mode_i ? CMD_SEC_SEG : CMD_NONE;
            4'b0010: cmd_o = mode_i ? CMD_PAGE    : CMD_NONE;
            4'b0011: cmd_o = mode_i ? CMD_NONE    : CMD_WORD;
            4'b0001: cmd_o = mode_i ? CMD_NONE    : CMD_ROW;
            4'b0000: cmd_o = CMD_CFG_BYTE;
            default: cmd_o = CMD_NONE;
        endcase
    end

    always_comb begin
        dur_m1_o = '0;
        unique case (cmd_o)
            CMD_BULK:               dur_m1_o = CNT_W'(T_BULK - 1);
            CMD_GEN_SEG, CMD_SEC_SEG: dur_m1_o = CNT_W'(T_SEG - 1);
            CMD_PAGE:               dur_m1_o = CNT_W'(T_PAGE - 1);
            CMD_ROW:                dur_m1_o = CNT_W'(T_ROW - 1);
            CMD_WORD:               dur_m1_o = CNT_W'(T_WORD - 1);
            CMD_CFG_BYTE:           dur_m1_o = CNT_W'(T_CFG - 1);
            default:                dur_m1_o = '0;
        endcase
    end

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             abort_i,
    output logic             busy_o,
    output logic             last_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (abort_i) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (load_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = load_val_i;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;
    assign last_o = tmr_q.busy && (tmr_q.cnt == '0);

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        load_i |-> !tmr_q.busy); // R9

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!por_n)
        (tmr_q.busy && !abort_i && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1)); // R5

endmodule

// File: rtl/nvm_op_ctrl.sv
module nvm_op_ctrl
    import nvm_op_pkg::*;
#(
    parameter int T_BULK = 12,
    parameter int T_SEG  = 10,
    parameter int T_PAGE = 8,
    parameter int T_ROW  = 6,
    parameter int T_WORD = 4,
    parameter int T_CFG  = 3
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        op_start,
    output logic [2:0]  op_cmd,
    output logic        op_busy
);

    localparam int T_MAX_A = (T_BULK > T_SEG)  ? T_BULK : T_SEG;
    localparam int T_MAX_B = (T_PAGE > T_ROW)  ? T_PAGE : T_ROW;
    localparam int T_MAX_C = (T_WORD > T_CFG)  ? T_WORD : T_CFG;
    localparam int T_MAX_D = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int T_MAX   = (T_MAX_D > T_MAX_C) ? T_MAX_D : T_MAX_C;
    localparam int CNT_W   = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    typedef struct packed {
        logic             start;
        logic             wren;
        logic             err;
        logic             mode;
        logic [SEL_W-1:0] sel;
        cmd_e             cmd;
        logic             strobe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    cmd_e             dec_cmd;
    logic [CNT_W-1:0] dec_dur_m1;
    logic             tmr_load;
    logic             tmr_abort;
    logic             tmr_busy;
    logic             tmr_last;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[BIT_ERR:7], wr_data[5:4]};

    nvm_op_decode #(
        .CNT_W  (CNT_W),
        .T_BULK (T_BULK),
        .T_SEG  (T_SEG),
        .T_PAGE (T_PAGE),
        .T_ROW  (T_ROW),
        .T_WORD (T_WORD),
        .T_CFG  (T_CFG)
    ) u_decode (
        .mode_i   (wr_data[BIT_MODE]),
        .sel_i    (wr_data[SEL_W-1:0]),
        .cmd_o    (dec_cmd),
        .dur_m1_o (dec_dur_m1)
    );

    nvm_op_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .por_n      (por_n),
        .load_i     (tmr_load),
        .load_val_i (dec_dur_m1),
        .abort_i    (tmr_abort),
        .busy_o     (tmr_busy),
        .last_o     (tmr_last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.strobe = 1'b0;
        tmr_load     = 1'b0;
        tmr_abort    = 1'b0;
        if (!rst_n) begin
            if (tmr_busy) begin
                tmr_abort   = 1'b1;
                ctl_d.start = 1'b0;
                ctl_d.err   = 1'b1;
                ctl_d.cmd   = CMD_NONE;
            end
        end else begin
            if (tmr_last) begin
                ctl_d.start = 1'b0;
                ctl_d.cmd   = CMD_NONE;
            end
            if (wr_en) begin
                ctl_d.wren = wr_data[BIT_WREN];
                if (!tmr_busy) begin
                    ctl_d.mode = wr_data[BIT_MODE];
                    ctl_d.sel  = wr_data[SEL_W-1:0];
                    if (wr_data[BIT_START]) begin
                        if (wr_data[BIT_WREN] && (dec_cmd != CMD_NONE)) begin
                            ctl_d.start  = 1'b1;
                            ctl_d.cmd    = dec_cmd;
                            ctl_d.strobe = 1'b1;
                            tmr_load     = 1'b1;
                        end else begin
                            ctl_d.err = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data                = '0;
        rd_data[BIT_START]     = ctl_q.start;
        rd_data[BIT_WREN]      = ctl_q.wren;
        rd_data[BIT_ERR]       = ctl_q.err;
        rd_data[BIT_MODE]      = ctl_q.mode;
        rd_data[SEL_W-1:0]     = ctl_q.sel;
    end

    assign op_start = ctl_q.strobe;
    assign op_cmd   = ctl_q.cmd;
    assign op_busy  = tmr_busy;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        op_start |=> !op_start); // R4

    AST_STROBE_WITH_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        op_start |-> (op_busy && op_cmd != CMD_NONE && ctl_q.wren)); // R4

    AST_BUSY_HAS_START: assert property (@(posedge clk) disable iff (!por_n)
        op_busy |-> ctl_q.start); // R6

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (op_busy && !op_start) |-> $stable(op_cmd)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.err |=> ctl_q.err); // R8

    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && op_busy) |=> (!op_busy && ctl_q.err && !ctl_q.start)); // R11

    AST_IDLE_RST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !op_busy) |=> $stable(rd_data)); // R10

    AST_PROG_MODE0: assert property (@(posedge clk) disable iff (!por_n)
        (op_start && (op_cmd == CMD_ROW || op_cmd == CMD_WORD)) |-> !ctl_q.mode); // R3

endmodule

// File: tb/nvm_op_ctrl_tb_top.sv
module nvm_op_ctrl_tb_top;

    localparam int P_BULK = 12;
    localparam int P_SEG  = 10;
    localparam int P_PAGE = 8;
    localparam int P_ROW  = 6;
    localparam int P_WORD = 4;
    localparam int P_CFG  = 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        op_start;
    logic [2:0]  op_cmd;
    logic        op_busy;

    always #2 clk = ~clk;

    nvm_op_ctrl #(
        .T_BULK (P_BULK), .T_SEG (P_SEG), .T_PAGE (P_PAGE),
        .T_ROW  (P_ROW),  .T_WORD(P_WORD), .T_CFG (P_CFG)
    ) dut_i (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .op_start (op_start),
        .op_cmd   (op_cmd),
        .op_busy  (op_busy)
    );

    // behavioural reference state
    int m_start, m_wren, m_err, m_mode, m_sel, m_cmd, m_left, m_strobe;
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_req = "R2";

    function automatic int ref_cmd(int mode, int sel);
        if (sel == 0) return 7;
        if (mode == 1) begin
            if (sel == 15) return 1;
            if (sel == 13) return 2;
            if (sel == 12) return 3;
            if (sel == 2)  return 4;
        end else begin
            if (sel == 1) return 5;
            if (sel == 3) return 6;
        end
        return 0;
    endfunction

    function automatic int ref_len(int c);
        case (c)
            1: return P_BULK;
            2, 3: return P_SEG;
            4: return P_PAGE;
            5: return P_ROW;
            6: return P_WORD;
            default: return P_CFG;
        endcase
    endfunction

    always @(posedge clk) begin
        int was_busy;
        cycles++;
        if (!por_n) begin
            m_start = 0; m_wren = 0; m_err = 0; m_mode = 0; m_sel = 0;
            m_cmd = 0; m_left = 0; m_strobe = 0;
        end else begin
            m_strobe = 0;
            was_busy = (m_left > 0);
            if (!rst_n) begin
                if (was_busy) begin
                    m_left = 0; m_start = 0; m_cmd = 0; m_err = 1;
                end
            end else begin
                if (was_busy) begin
                    m_left--;
                    if (m_left == 0) begin
                        m_start = 0; m_cmd = 0;
                    end
                end
                if (wr_en) begin
                    m_wren = wr_data[14];
                    if (!was_busy) begin
                        int c;
                        m_mode = wr_data[6];
                        m_sel  = int'(wr_data[3:0]);
                        c = ref_cmd(m_mode, m_sel);
                        if (wr_data[15]) begin
                            if (wr_data[14] && c != 0) begin
                                m_start = 1; m_cmd = c; m_left = ref_len(c); m_strobe = 1;
                            end else begin
                                m_err = 1;
                            end
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        logic [15:0] exp_rd;
        exp_rd = {m_start[0], m_wren[0], m_err[0], 6'b0, m_mode[0], 2'b0, m_sel[3:0]};
        n_checks++;
        if (rd_data !== exp_rd || op_busy !== (m_left > 0) || op_start !== m_strobe[0]
            || op_cmd !== m_cmd[2:0]) begin
            n_fail++;
            $display("FAIL %s t=%0t rd=%h/%h busy=%b/%b strobe=%b/%b cmd=%0d/%0d (actual/expected)",
                     cur_req, $time, rd_data, exp_rd, op_busy, (m_left > 0), op_start,
                     m_strobe[0], op_cmd, m_cmd);
        end
    end

    task automatic wr(input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk); #1;
        por_n = 1'b0;
        idle(2); #1;
        por_n = 1'b1;
    endtask

    function automatic logic [15:0] go(input logic mode, input logic [3:0] sel);
        return {2'b11, 7'b0, mode, 2'b0, sel};
    endfunction

    initial begin
        idle(2); #1;
        por_n = 1'b1;
        cur_req = "R2"; idle(2);

        cur_req = "R1"; wr(16'h5FBF); idle(2);   // reads back 0x400F
        cur_req = "R8"; wr(16'h2000); idle(2);   // error bit not settable

        // R3 R4 R5: every valid command
        cur_req = "R3"; wr(go(1'b1, 4'hF)); idle(P_BULK + 2);
        cur_req = "R4"; wr(go(1'b1, 4'hD)); idle(P_SEG + 2);
        cur_req = "R5"; wr(go(1'b1, 4'hC)); idle(P_SEG + 2);
        cur_req = "R3"; wr(go(1'b1, 4'h2)); idle(P_PAGE + 2);
        cur_req = "R3"; wr(go(1'b0, 4'h1)); idle(P_ROW + 2);
        cur_req = "R5"; wr(go(1'b0, 4'h3)); idle(P_WORD + 2);
        cur_req = "R3"; wr(go(1'b0, 4'h0)); idle(P_CFG + 2);
        cur_req = "R3"; wr(go(1'b1, 4'h0)); idle(P_CFG + 2);

        // R6: start cannot be cleared, R9: selector frozen, wren writable
        cur_req = "R6"; wr(go(1'b1, 4'hF)); idle(2);
        wr(16'h4000); idle(1);
        cur_req = "R9"; wr(16'hC041); wr(16'h0003); idle(P_BULK + 2);

        // R7: wren low
        cur_req = "R7"; do_por(); idle(1);
        wr(16'h8000 | 16'h0043); idle(3);
        cur_req = "R8"; wr(16'h4000); idle(2);
        // R7: invalid pairs
        cur_req = "R7"; do_por(); idle(1);
        wr(go(1'b0, 4'hF)); idle(2);
        wr(go(1'b1, 4'h3)); wr(go(1'b1, 4'h1)); wr(go(1'b0, 4'h2));
        wr(go(1'b1, 4'hE)); wr(go(1'b0, 4'hB)); wr(go(1'b0, 4'hD));
        wr(go(1'b0, 4'hC)); wr(go(1'b1, 4'h5)); idle(2);

        // R10: system reset while idle
        cur_req = "R10"; do_por(); idle(1);
        wr(16'h404D); idle(1);
        @(negedge clk); #1; rst_n = 1'b0;
        wr_en = 1'b1; wr_data = go(1'b1, 4'hF);
        idle(3); #1; wr_en = 1'b0; rst_n = 1'b1; idle(2);

        // R11: system reset mid-operation
        cur_req = "R11"; wr(go(1'b1, 4'hF)); idle(4); #1;
        rst_n = 1'b0; idle(1); #1; rst_n = 1'b1; idle(3);
        cur_req = "R11"; wr(go(1'b0, 4'h3)); idle(P_WORD + 2);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule